// File: doc/BRIEF.md
# Remappable Register File with Custom Structures

This block is a sixteen-entry processor register file in front of which sits a small redirection table. Each architected specifier can be bound, by a one-cycle map command, to one of five small storage structures. Once bound, ordinary reads and writes of that specifier are served by the structure instead of the register file. The operand field never widens, yet a single specifier can hold several live values: a loop-carried value in a delay queue, a run of temporaries on a stack, or a repeating table in a ring.

Structure identifiers are fixed. 0 and 1 are delay queues (non-destructive read). 2 is a draining queue. 3 is a stack. 4 is a ring buffer. A map command carries a specifier, a 3-bit depth and a structure identifier. Reads are combinational on the read specifier. Writes, pops, pointer moves and map changes take effect on the rising clock edge. A sticky error output reports underflow and stack overflow.

Top module: `rmrf_top`

## Requirements
- R1: After reset all sixteen registers read zero, no specifier is bound, and `err` is 0.
- R2: Every access looks up the table. For an unbound specifier, `rd_data` shows the register combinationally, and a write updates the register at the clock edge.
- R3: A write to a bound specifier goes to its structure and leaves the register file unchanged. After unbinding, the register's old value reads back.
- R4: A map command with depth 1 to 7 and identifier 0 to 4 binds the specifier in one cycle. It also empties the structure and sets its depth. An identifier of 5 to 7 with a nonzero depth is ignored.
- R5: Repeating a command with the same specifier and the same identifier unbinds the specifier. A command with depth 0 unbinds a bound specifier and has no effect on an unbound one.
- R6: Delay queue (ids 0, 1): a write appends, and once `depth` entries are held it drops the oldest. A read returns the oldest entry without removing it, but only when exactly `depth` entries are held; otherwise it returns 0 and sets `err`.
- R7: Draining queue (id 2): a read returns and removes the oldest entry. A write to a full queue drops the oldest. A read of an empty queue returns 0 and sets `err`.
- R8: Stack (id 3): reads return writes in reverse order. A write to a full stack with no read in the same cycle is ignored and sets `err`. A read of an empty stack returns 0 and sets `err`.
- R9: Ring (id 4): writes fill slots at a write pointer that wraps modulo `depth`. Reads return the slot at a separate read pointer, which then wraps modulo `depth`; entries are kept. A read before any write returns 0 and sets `err`.
- R10: `err` stays 1 until reset, whatever accesses follow.
- R11: When a read and a write reach the same specifier in one cycle, the read returns the contents from before the edge and both effects apply. On a stack the top entry is replaced. On a queue the head leaves and the new value is appended. A full stack raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| map_valid | input | 1 | Map command strobe |
| map_spec | input | 4 | Specifier to bind or unbind |
| map_depth | input | 3 | Structure depth, 0 requests unbind |
| map_sel | input | 3 | Structure identifier |
| rd_en | input | 1 | Read strobe (pops or advances a bound structure) |
| rd_spec | input | 4 | Read specifier |
| rd_data | output | 16 | Read value, combinational |
| wr_en | input | 1 | Write strobe |
| wr_spec | input | 4 | Write specifier |
| wr_data | input | 16 | Write value |
| err | output | 1 | Sticky underflow/overflow flag |

## Verification
A read and a write can land on the same bound structure in one cycle: a pop and a push on the stack, or a removal and an append on a full queue. The bench provokes this by driving both strobes to one specifier in a single cycle. The read value is judged against the contents before the edge. Follow-up reads then confirm that the replaced top, or the rotated queue, holds the expected values and that `err` stays 0. The same collision on an unbound specifier and on a full one-deep stack is checked the same way.

// File: rtl/rmrf_pkg.sv
// Package: shared structure kinds and the fixed identifier-to-kind assignment.
// Assumes five structures; identifiers 0 and 1 are delay queues.
package rmrf_pkg;

    typedef enum logic [1:0] {
        KIND_DELAY,
        KIND_DRAIN,
        KIND_STACK,
        KIND_RING
    } kind_e;

    localparam int NUM_STRUCT = 5;

    // Map a structure identifier to the kind of storage it implements.
    function automatic kind_e kind_of(input int idx);
        if (idx < 2)       return KIND_DELAY;
        else if (idx == 2) return KIND_DRAIN;
        else if (idx == 3) return KIND_STACK;
        else               return KIND_RING;
    endfunction

endpackage

// File: rtl/rmrf_arch_file.sv
// Module: the ordinary architected register file, one write port and one
// combinational read port. Assumes the caller gates writes for bound specifiers.
module rmrf_arch_file #(
    parameter int ARCH_N = 16,
    parameter int DATA_W = 16,
    localparam int SPEC_W = $clog2(ARCH_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SPEC_W-1:0] wspec,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SPEC_W-1:0] rspec,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [ARCH_N];

    // Clear on reset, otherwise store the write value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wspec] <= wdata;
        end
    end

    // Combinational read.
    assign rdata = regs[rspec];

endmodule

// File: rtl/rmrf_map_table.sv
// Module: redirection table. Holds a bound flag and a structure identifier per
// specifier. Decodes map commands into bind/unbind and raises a one-cycle load
// strobe to the target structure on a bind. Lookups reflect the table before
// any command in the same cycle.
module rmrf_map_table #(
    parameter int ARCH_N     = 16,
    parameter int CFG_W      = 3,
    parameter int NUM_STRUCT = 5,
    localparam int SPEC_W    = $clog2(ARCH_N),
    localparam int SID_W     = $clog2(NUM_STRUCT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [SPEC_W-1:0]     cmd_spec,
    input  logic [CFG_W-1:0]      cmd_depth,
    input  logic [SID_W-1:0]      cmd_sid,
    input  logic [SPEC_W-1:0]     rd_spec,
    input  logic [SPEC_W-1:0]     wr_spec,
    output logic                  rd_hit,
    output logic [SID_W-1:0]      rd_sid,
    output logic                  wr_hit,
    output logic [SID_W-1:0]      wr_sid,
    output logic [NUM_STRUCT-1:0] load,
    output logic [ARCH_N-1:0]     bound
);

    logic [SID_W-1:0] bind_sid [ARCH_N];
    logic sid_ok, same_sid, do_unbind, do_bind;

    // Classify the incoming command.
    always_comb begin
        sid_ok    = (32'(cmd_sid) < NUM_STRUCT);
        same_sid  = (bind_sid[cmd_spec] == cmd_sid);
        do_unbind = cmd_valid && bound[cmd_spec] &&
                    ((cmd_depth == '0) || (sid_ok && same_sid));
        do_bind   = cmd_valid && !do_unbind && sid_ok && (cmd_depth != '0);
    end

    // One load strobe per structure.
    for (genvar g = 0; g < NUM_STRUCT; g++) begin : g_load
        assign load[g] = do_bind && (cmd_sid == SID_W'(g));
    end

    // Update the table entry named by the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bound <= '0;
            for (int i = 0; i < ARCH_N; i++) bind_sid[i] <= '0;
        end else if (do_unbind) begin
            bound[cmd_spec] <= 1'b0;
        end else if (do_bind) begin
            bound[cmd_spec]    <= 1'b1;
            bind_sid[cmd_spec] <= cmd_sid;
        end
    end

    // Lookups for both access ports.
    assign rd_hit = bound[rd_spec];
    assign rd_sid = bind_sid[rd_spec];
    assign wr_hit = bound[wr_spec];
    assign wr_sid = bind_sid[wr_spec];

endmodule

// File: rtl/rmrf_slot_unit.sv
// Module: one custom structure with 2**CFG_W slots, of which `depth` are used.
// KIND selects delay queue, draining queue, stack or ring. Read data is
// combinational and is zero when the read would underflow. A load empties the
// structure and has priority over any access in the same cycle.
module rmrf_slot_unit
    import rmrf_pkg::*;
#(
    parameter kind_e KIND   = KIND_DELAY,
    parameter int    DATA_W = 16,
    parameter int    CFG_W  = 3,
    localparam int   SLOTS  = 1 << CFG_W,
    localparam int   SUM_W  = CFG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CFG_W-1:0]  load_depth,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fault,
    output logic              wr_fault
);

    logic [DATA_W-1:0] mem [SLOTS];
    logic [CFG_W-1:0]  depth, head, cnt, wptr;
    logic [CFG_W-1:0]  top, tail, head_nx, wptr_nx;
    logic              full, empty, rd_ok, pop;

    // Reduce a sum below 2*depth into the range 0..depth-1.
    function automatic logic [CFG_W-1:0] wrap_idx(input logic [SUM_W-1:0] s,
                                                  input logic [CFG_W-1:0] d);
        logic [SUM_W-1:0] r;
        r = (s >= {1'b0, d}) ? s - {1'b0, d} : s;
        return r[CFG_W-1:0];
    endfunction

    // Occupancy, pointer arithmetic and read availability.
    always_comb begin
        full    = (cnt == depth);
        empty   = (cnt == '0);
        top     = empty ? '0 : cnt - 1'b1;
        tail    = wrap_idx({1'b0, head} + {1'b0, cnt}, depth);
        head_nx = wrap_idx({1'b0, head} + SUM_W'(1), depth);
        wptr_nx = wrap_idx({1'b0, wptr} + SUM_W'(1), depth);
        case (KIND)
            KIND_DELAY: rd_ok = full && !empty;
            default:    rd_ok = !empty;
        endcase
        pop      = rd_req && rd_ok;
        rd_data  = !rd_ok ? '0 : (KIND == KIND_STACK) ? mem[top] : mem[head];
        rd_fault = rd_req && !rd_ok;
        wr_fault = (KIND == KIND_STACK) && wr_req && full && !rd_req;
    end

    // Apply load, push, pop and pointer moves for the selected kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
            head  <= '0;
            cnt   <= '0;
            wptr  <= '0;
        end else if (load) begin
            depth <= load_depth;
            head  <= '0;
            cnt   <= '0;
            wptr  <= '0;
        end else if (KIND == KIND_STACK) begin
            if (wr_req && pop) begin
                mem[top] <= wr_data;
            end else if (wr_req && !full) begin
                mem[cnt] <= wr_data;
                cnt      <= cnt + 1'b1;
            end else if (pop) begin
                cnt <= cnt - 1'b1;
            end
        end else if (KIND == KIND_RING) begin
            if (wr_req) begin
                mem[wptr] <= wr_data;
                wptr      <= wptr_nx;
                if (!full) cnt <= cnt + 1'b1;
            end
            if (pop) head <= head_nx;
        end else begin
            if (wr_req) mem[tail] <= wr_data;
            if ((KIND == KIND_DRAIN && pop) || (wr_req && full)) head <= head_nx;
            if (wr_req && !full && !(KIND == KIND_DRAIN && pop)) cnt <= cnt + 1'b1;
            else if (KIND == KIND_DRAIN && pop && !wr_req)       cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/rmrf_top.sv
// Module: top of the remappable register file. Routes each access through the
// table to the register file or to one of the five structures, and keeps the
// sticky error flag. Assumes one read and one write port per cycle.
module rmrf_top
    import rmrf_pkg::*;
#(
    parameter int ARCH_N  = 16,
    parameter int DATA_W  = 16,
    parameter int CFG_W   = 3,
    localparam int SPEC_W = $clog2(ARCH_N),
    localparam int SID_W  = $clog2(NUM_STRUCT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_valid,
    input  logic [SPEC_W-1:0] map_spec,
    input  logic [CFG_W-1:0]  map_depth,
    input  logic [SID_W-1:0]  map_sel,
    input  logic              rd_en,
    input  logic [SPEC_W-1:0] rd_spec,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [SPEC_W-1:0] wr_spec,
    input  logic [DATA_W-1:0] wr_data,
    output logic              err
);

    logic                  rd_hit, wr_hit, rd_fault, wr_fault;
    logic [SID_W-1:0]      rd_sid, wr_sid;
    logic [NUM_STRUCT-1:0] unit_load, unit_rf, unit_wf;
    logic [ARCH_N-1:0]     bound_vec;
    logic [DATA_W-1:0]     arch_rdata;
    logic [DATA_W-1:0]     unit_rdata [NUM_STRUCT];

    rmrf_map_table #(.ARCH_N(ARCH_N), .CFG_W(CFG_W), .NUM_STRUCT(NUM_STRUCT)) u_map (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(map_valid), .cmd_spec(map_spec), .cmd_depth(map_depth), .cmd_sid(map_sel),
        .rd_spec(rd_spec), .wr_spec(wr_spec),
        .rd_hit(rd_hit), .rd_sid(rd_sid), .wr_hit(wr_hit), .wr_sid(wr_sid),
        .load(unit_load), .bound(bound_vec)
    );

    rmrf_arch_file #(.ARCH_N(ARCH_N), .DATA_W(DATA_W)) u_arch (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && !wr_hit), .wspec(wr_spec), .wdata(wr_data),
        .rspec(rd_spec), .rdata(arch_rdata)
    );

    // One structure per identifier, kind chosen by the package.
    for (genvar g = 0; g < NUM_STRUCT; g++) begin : g_unit
        rmrf_slot_unit #(.KIND(kind_of(g)), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .load(unit_load[g]), .load_depth(map_depth),
            .rd_req(rd_en && rd_hit && (rd_sid == SID_W'(g))),
            .wr_req(wr_en && wr_hit && (wr_sid == SID_W'(g))),
            .wr_data(wr_data),
            .rd_data(unit_rdata[g]), .rd_fault(unit_rf[g]), .wr_fault(unit_wf[g])
        );
    end

    // Select the read source from the lookup.
    always_comb begin
        rd_data = arch_rdata;
        if (rd_hit) begin
            rd_data = '0;
            for (int i = 0; i < NUM_STRUCT; i++)
                if (rd_sid == SID_W'(i)) rd_data = unit_rdata[i];
        end
    end

    assign rd_fault = |unit_rf;
    assign wr_fault = |unit_wf;

    // Sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                    err <= 1'b0;
        else if (rd_fault || wr_fault) err <= 1'b1;
    end

endmodule

// File: rtl/rmrf_checker.sv
// Module: protocol checks for rmrf_top, attached with bind below.
module rmrf_checker
    import rmrf_pkg::*;
#(
    parameter int ARCH_N  = 16,
    parameter int DATA_W  = 16,
    parameter int CFG_W   = 3,
    localparam int SPEC_W = $clog2(ARCH_N),
    localparam int SID_W  = $clog2(NUM_STRUCT)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  map_valid,
    input logic [SPEC_W-1:0]     map_spec,
    input logic [CFG_W-1:0]      map_depth,
    input logic [SID_W-1:0]      map_sel,
    input logic                  rd_en,
    input logic [DATA_W-1:0]     rd_data,
    input logic                  err,
    input logic                  rd_hit,
    input logic                  rd_fault,
    input logic [ARCH_N-1:0]     bound_vec,
    input logic [NUM_STRUCT-1:0] unit_load,
    input logic [DATA_W-1:0]     arch_rdata
);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // Underflow of any structure (R6, R7, R9 as well).
    assert_underflow_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_fault) |-> (rd_data == '0));

    assert_fault_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_fault) |=> err);

    assert_unbound_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hit) |-> (rd_data == arch_rdata));

    assert_bind_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid && map_depth != '0 && 32'(map_sel) < NUM_STRUCT && !bound_vec[map_spec])
        |=> bound_vec[$past(map_spec)]);

    assert_depth0_unbinds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid && map_depth == '0) |=> !bound_vec[$past(map_spec)]);

    assert_single_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_load));

endmodule

bind rmrf_top rmrf_checker #(.ARCH_N(ARCH_N), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .map_valid(map_valid), .map_spec(map_spec),
    .map_depth(map_depth), .map_sel(map_sel), .rd_en(rd_en), .rd_data(rd_data),
    .err(err), .rd_hit(rd_hit), .rd_fault(rd_fault), .bound_vec(bound_vec),
    .unit_load(unit_load), .arch_rdata(arch_rdata)
);

// File: tb/rmrf_top_test.sv
// Bench: sweeps every structure over depths 1..7 and checks values computed here.
module rmrf_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_valid = 1'b0;
    logic [3:0]  map_spec = '0;
    logic [2:0]  map_depth = '0;
    logic [2:0]  map_sel = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_spec = '0;
    logic [15:0] rd_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_spec = '0;
    logic [15:0] wr_data = '0;
    logic        err;

    int n_chk = 0;
    int n_fail = 0;

    rmrf_top uut (
        .clk(clk), .rst_n(rst_n), .map_valid(map_valid), .map_spec(map_spec),
        .map_depth(map_depth), .map_sel(map_sel), .rd_en(rd_en), .rd_spec(rd_spec),
        .rd_data(rd_data), .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data), .err(err)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_err(input string req, input logic exp);
        chk(req, {15'b0, err}, {15'b0, exp});
    endtask

    // All tasks start and end just after a falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        map_valid = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic map_cmd(input logic [3:0] s, input logic [2:0] d, input logic [2:0] id);
        map_valid = 1'b1; map_spec = s; map_depth = d; map_sel = id;
        @(negedge clk);
        map_valid = 1'b0;
    endtask

    task automatic wr(input logic [3:0] s, input logic [15:0] v);
        wr_en = 1'b1; wr_spec = s; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, input logic [15:0] exp, input string req);
        rd_en = 1'b1; rd_spec = s;
        #1 chk(req, rd_data, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rdwr(input logic [3:0] s, input logic [15:0] exp, input logic [15:0] v,
                        input string req);
        rd_en = 1'b1; rd_spec = s;
        wr_en = 1'b1; wr_spec = s; wr_data = v;
        #1 chk(req, rd_data, exp);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    function automatic logic [15:0] val(input int id, input int d, input int k);
        return 16'(16'h1000 + id * 256 + d * 16 + k);
    endfunction

    function automatic logic [15:0] arch_val(input int i);
        return 16'(16'h2000 + i * 37);
    endfunction

    initial begin
        do_reset();

        // R1: reset state
        chk_err("R1", 1'b0);
        for (int i = 0; i < 16; i++) rd(4'(i), 16'h0000, "R1");

        // R2: plain register file
        for (int i = 0; i < 16; i++) wr(4'(i), arch_val(i));
        for (int i = 0; i < 16; i++) rd(4'(i), arch_val(i), "R2");

        // R3 and R5: bound writes bypass the register file; repeat unbinds
        map_cmd(4'd5, 3'd4, 3'd3);
        wr(4'd5, 16'hAAAA);
        rd(4'd5, 16'hAAAA, "R3");
        map_cmd(4'd5, 3'd4, 3'd3);
        rd(4'd5, arch_val(5), "R3");
        map_cmd(4'd6, 3'd2, 3'd4);
        wr(4'd6, 16'hBBBB);
        map_cmd(4'd6, 3'd0, 3'd0);
        rd(4'd6, arch_val(6), "R5");
        map_cmd(4'd7, 3'd0, 3'd2);
        wr(4'd7, 16'hCCCC);
        rd(4'd7, 16'hCCCC, "R5");
        // R4: invalid identifier ignored
        map_cmd(4'd8, 3'd3, 3'd6);
        wr(4'd8, 16'h5555);
        rd(4'd8, 16'h5555, "R4");
        chk_err("R4", 1'b0);

        // R11: read and write in the same cycle
        map_cmd(4'd2, 3'd4, 3'd3);
        wr(4'd2, 16'd10); wr(4'd2, 16'd20);
        rdwr(4'd2, 16'd20, 16'd30, "R11");
        rd(4'd2, 16'd30, "R11"); rd(4'd2, 16'd10, "R11");
        map_cmd(4'd3, 3'd2, 3'd2);
        wr(4'd3, 16'd1); wr(4'd3, 16'd2);
        rdwr(4'd3, 16'd1, 16'd3, "R11");
        rd(4'd3, 16'd2, "R11"); rd(4'd3, 16'd3, "R11");
        map_cmd(4'd4, 3'd2, 3'd0);
        wr(4'd4, 16'd5); wr(4'd4, 16'd6);
        rdwr(4'd4, 16'd5, 16'd7, "R11");
        rd(4'd4, 16'd6, "R11");
        rdwr(4'd9, arch_val(9), 16'h0099, "R11");
        rd(4'd9, 16'h0099, "R11");
        map_cmd(4'd12, 3'd1, 3'd3);
        wr(4'd12, 16'd40);
        rdwr(4'd12, 16'd40, 16'd41, "R11");
        rd(4'd12, 16'd41, "R11");
        chk_err("R11", 1'b0);
        do_reset();

        // R6: delay queues, every depth
        for (int id = 0; id < 2; id++) begin
            for (int d = 1; d < 8; d++) begin
                map_cmd(4'd1, 3'(d), 3'(id));
                for (int k = 0; k < d + 3; k++) begin
                    wr(4'd1, val(id, d, k));
                    if (k + 1 >= d) begin
                        rd(4'd1, val(id, d, k + 1 - d), "R6");
                        rd(4'd1, val(id, d, k + 1 - d), "R6");
                    end
                end
                map_cmd(4'd1, 3'(d), 3'(id));
            end
        end
        chk_err("R6", 1'b0);
        map_cmd(4'd1, 3'd3, 3'd0);
        wr(4'd1, 16'h0123);
        rd(4'd1, 16'h0000, "R6");
        chk_err("R6", 1'b1);
        do_reset();

        // R7: draining queue, every depth
        for (int d = 1; d < 8; d++) begin
            map_cmd(4'd1, 3'(d), 3'd2);
            for (int k = 0; k < d + 2; k++) wr(4'd1, val(2, d, k));
            for (int j = 0; j < d; j++) rd(4'd1, val(2, d, j + 2), "R7");
            map_cmd(4'd1, 3'(d), 3'd2);
        end
        chk_err("R7", 1'b0);
        map_cmd(4'd1, 3'd3, 3'd2);
        rd(4'd1, 16'h0000, "R7");
        chk_err("R7", 1'b1);
        do_reset();

        // R8: stack, every depth
        for (int d = 1; d < 8; d++) begin
            map_cmd(4'd1, 3'(d), 3'd3);
            for (int k = 0; k < d; k++) wr(4'd1, val(3, d, k));
            for (int k = d - 1; k >= 0; k--) rd(4'd1, val(3, d, k), "R8");
            map_cmd(4'd1, 3'(d), 3'd3);
        end
        chk_err("R8", 1'b0);
        map_cmd(4'd1, 3'd2, 3'd3);
        wr(4'd1, 16'h00A1); wr(4'd1, 16'h00B2);
        chk_err("R8", 1'b0);
        wr(4'd1, 16'h00C3);
        chk_err("R8", 1'b1);
        rd(4'd1, 16'h00B2, "R8");
        rd(4'd1, 16'h00A1, "R8");
        rd(4'd1, 16'h0000, "R8");
        // R10: flag holds through later normal traffic
        wr(4'd9, 16'h0077);
        rd(4'd9, 16'h0077, "R10");
        chk_err("R10", 1'b1);
        do_reset();
        chk_err("R10", 1'b0);

        // R9: ring, every depth; slot 0 overwritten by the extra write
        for (int d = 1; d < 8; d++) begin
            map_cmd(4'd1, 3'(d), 3'd4);
            for (int k = 0; k <= d; k++) wr(4'd1, val(4, d, k));
            for (int i = 0; i < 2 * d; i++)
                rd(4'd1, ((i % d) == 0) ? val(4, d, d) : val(4, d, i % d), "R9");
            map_cmd(4'd1, 3'(d), 3'd4);
        end
        chk_err("R9", 1'b0);
        map_cmd(4'd1, 3'd2, 3'd4);
        rd(4'd1, 16'h0000, "R9");
        chk_err("R9", 1'b1);
        do_reset();
        chk_err("R1", 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule